// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block executes the stack-based and flow-changing operations of an 8-bit processor core with a 16-bit address space. It owns the program counter and the stack pointer and moves data between them, the caller's registers and a byte-wide synchronous memory. Each memory access takes one cycle, and read data returns one cycle after the address is presented. Instruction decoding and arithmetic are done elsewhere. The decoder hands this block a command code, a 16-bit operand (a register pair or a target address), the accumulator, the HL pair and the current flags.

Commands are accepted with a valid/ready handshake. The sequencer then runs its memory cycles and raises a one-cycle completion pulse. At that pulse the new program counter, the new stack pointer and any popped or exchanged value are visible on the outputs. Addresses at or above a configured memory size read back as all ones, and writes to them never reach the memory port.

Top module: `stk_xfer_unit`

## Requirements
- R1: Push pair (code 0) writes the high byte at SP-1 in the first cycle after acceptance and the low byte at SP-2 in the second. Done rises in the third cycle, with SP reduced by 2 and PC advanced by 1.
- R2: Pop pair (code 1) reads SP in the first cycle after acceptance and SP+1 in the second. The byte from SP is the low half of the result. Done rises in the fourth cycle, with SP raised by 2 and PC advanced by 1.
- R3: Push status (code 2) writes the accumulator as the high byte. The low byte is sign in bit 7, zero in bit 6, auxiliary carry in bit 4, parity in bit 2, constant 1 in bit 1 and carry in bit 0, with bits 5 and 3 at 0. Flag inputs are ordered {sign, zero, aux, parity, carry} from bit 4 down to bit 0.
- R4: Pop status (code 3) loads the accumulator output from the high byte and each flag output from the bit position given in R3. Popped bits 5, 3 and 1 have no effect.
- R5: The 3-bit condition field selects the test: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear, 7 sign set.
- R6: Call (code 4), and conditional call (code 5) when taken, pushes PC+3 as in R1 and then loads PC with the operand. A conditional call that is not taken makes no memory write, sets PC to PC+3 and raises done in the first cycle after acceptance.
- R7: Return (code 6), and conditional return (code 7) when taken, pops PC as in R2. A conditional return that is not taken sets PC to PC+1 and raises done in the first cycle after acceptance.
- R8: Restart (code 8) pushes PC+1 and loads PC with the 3-bit vector field multiplied by 8.
- R9: Exchange (code 9) reads SP and SP+1 and then writes L to SP and H to SP+1. The result output shows the old top word, SP is unchanged and PC advances by 1. Done rises in the fifth cycle after acceptance.
- R10: A write to an address at or above MEM_BYTES leaves the memory write enable low, and a read from such an address returns 0xFF.
- R11: SP and PC wrap modulo 2^16.
- R12: Ready is high only in the idle state. It drops in the cycle after acceptance and stays low through the one-cycle done pulse.
- R13: After reset PC, SP, result, accumulator and flag outputs are 0. Load SP (code 12) sets SP to the operand and leaves PC unchanged. Jump (code 10) loads PC with the operand. Conditional jump (code 11) loads the operand if the condition holds and PC+3 otherwise. Codes 13 to 15 change nothing. These commands finish in the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to accept |
| cmd_op | input | 4 | Command code |
| cmd_cond | input | 3 | Condition selector |
| cmd_vec | input | 3 | Restart vector number |
| cmd_word | input | 16 | Pair value, target address or new SP |
| acc_in | input | 8 | Accumulator for status push |
| flags_in | input | 5 | {sign, zero, aux, parity, carry} |
| hl_in | input | 16 | HL pair for exchange |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| result_out | output | 16 | Last popped pair or exchanged top word |
| acc_out | output | 8 | Accumulator restored by status pop |
| flags_out | output | 5 | Flags restored by status pop |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after address |

## Verification
Pairs with distinct high and low bytes are pushed and popped to show the byte order and the direction of the stack pointer. Status words with all flags clear and all flags set show the constant bit and each flag's position. Popping a word that has only bits 5 and 3 set, and one with every bit set, shows that the unused positions are discarded. Every condition code is tried with all flags clear and all flags set, for calls and returns, so a swapped code or inverted polarity shows up as a wrong PC or an unexpected bus cycle. Stacks placed across the memory limit and across address zero tell apart guarding, wrapping, and real writes.

// File: rtl/stk_xfer_pkg.sv
package stk_xfer_pkg;

   typedef enum logic [3:0] {
      OP_PUSH      = 4'd0,
      OP_POP       = 4'd1,
      OP_PUSH_ST   = 4'd2,
      OP_POP_ST    = 4'd3,
      OP_CALL      = 4'd4,
      OP_CALL_CC   = 4'd5,
      OP_RET       = 4'd6,
      OP_RET_CC    = 4'd7,
      OP_RESTART   = 4'd8,
      OP_XCHG_TOP  = 4'd9,
      OP_JMP       = 4'd10,
      OP_JMP_CC    = 4'd11,
      OP_LOAD_SP   = 4'd12
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WR_HI,
      ST_WR_LO,
      ST_RD_LO,
      ST_RD_HI,
      ST_RD_END,
      ST_XR_LO,
      ST_XR_HI,
      ST_XW_LO,
      ST_XW_HI,
      ST_FIN
   } state_e;

   // flag vector positions
   localparam int FLG_W   = 5;
   localparam int FLG_SGN = 4;
   localparam int FLG_ZRO = 3;
   localparam int FLG_AUX = 2;
   localparam int FLG_PAR = 1;
   localparam int FLG_CRY = 0;

endpackage

// File: rtl/stk_cond_eval.sv
module stk_cond_eval import stk_xfer_pkg::*; #(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] cond_sel,
   input  logic [FLG_W-1:0] flags,
   output logic             take
);

   generate
      if (SEL_W != 3) begin : g_bad_sel
         $error("stk_cond_eval: condition field must be 3 bits");
      end
   endgenerate

   // bit 0 of the selector picks polarity, bits 2:1 pick the flag
   logic picked;

   always_comb begin
      case (cond_sel[SEL_W-1:1])
         2'd0:    picked = flags[FLG_ZRO];
         2'd1:    picked = flags[FLG_CRY];
         2'd2:    picked = flags[FLG_PAR];
         default: picked = flags[FLG_SGN];
      endcase
      take = cond_sel[0] ? picked : ~picked;
   end

endmodule

// File: rtl/stk_status_codec.sv
module stk_status_codec import stk_xfer_pkg::*; #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0]   acc_in,
   input  logic [FLG_W-1:0]    flags_in,
   output logic [2*BYTE_W-1:0] packed_word,
   input  logic [2*BYTE_W-1:0] unpack_word,
   output logic [BYTE_W-1:0]   acc_out,
   output logic [FLG_W-1:0]    flags_out
);

   localparam int W2 = 2 * BYTE_W;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("stk_status_codec: status layout needs 8-bit bytes");
      end
   endgenerate

   assign packed_word = {acc_in,
                         flags_in[FLG_SGN], flags_in[FLG_ZRO], 1'b0,
                         flags_in[FLG_AUX], 1'b0, flags_in[FLG_PAR],
                         1'b1, flags_in[FLG_CRY]};

   assign acc_out = unpack_word[W2-1:BYTE_W];

   always_comb begin
      flags_out          = '0;
      flags_out[FLG_SGN] = unpack_word[7];
      flags_out[FLG_ZRO] = unpack_word[6];
      flags_out[FLG_AUX] = unpack_word[4];
      flags_out[FLG_PAR] = unpack_word[2];
      flags_out[FLG_CRY] = unpack_word[0];
   end

   // the spare positions are discarded on restore
   logic unused_spare;
   assign unused_spare = ^{unpack_word[5], unpack_word[3], unpack_word[1]};

endmodule

// File: rtl/stk_mem_guard.sv
module stk_mem_guard #(
   parameter int ADDR_W    = 16,
   parameter int BYTE_W    = 8,
   parameter int MEM_BYTES = 65536
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic              core_we,
   input  logic [BYTE_W-1:0] core_wdata,
   output logic [BYTE_W-1:0] core_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);

   localparam longint SPAN = longint'(1) << ADDR_W;
   localparam bit     FULL = (longint'(MEM_BYTES) >= SPAN);
   localparam logic [ADDR_W:0] LIMIT = MEM_BYTES[ADDR_W:0];

   assign mem_addr  = core_addr;
   assign mem_wdata = core_wdata;

   generate
      if (FULL) begin : g_full
         assign mem_we     = core_we;
         assign core_rdata = mem_rdata;
         logic unused_clk;
         assign unused_clk = ^{clk, rst_n};
      end else begin : g_limited
         logic miss;
         logic miss_q;
         assign miss = ({1'b0, core_addr} >= LIMIT);
         // read data comes back one cycle later, so the miss flag follows it
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) miss_q <= 1'b0;
            else        miss_q <= miss;
         end
         assign mem_we     = core_we & ~miss;
         assign core_rdata = miss_q ? '1 : mem_rdata;
      end
   endgenerate

endmodule

// File: rtl/stk_xfer_unit.sv
module stk_xfer_unit import stk_xfer_pkg::*; #(
   parameter int ADDR_W    = 16,
   parameter int BYTE_W    = 8,
   parameter int MEM_BYTES = 65536,
   parameter int VEC_W     = 3,
   parameter int COND_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [3:0]        cmd_op,
   input  logic [COND_W-1:0] cmd_cond,
   input  logic [VEC_W-1:0]  cmd_vec,
   input  logic [ADDR_W-1:0] cmd_word,
   input  logic [BYTE_W-1:0] acc_in,
   input  logic [4:0]        flags_in,
   input  logic [ADDR_W-1:0] hl_in,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] sp_out,
   output logic [ADDR_W-1:0] result_out,
   output logic [BYTE_W-1:0] acc_out,
   output logic [4:0]        flags_out,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);

   localparam int VEC_LSB  = 3;
   localparam int LEN_ONE  = 1;
   localparam int LEN_LONG = 3;

   generate
      if (ADDR_W != 2 * BYTE_W) begin : g_bad_pair
         $error("stk_xfer_unit: address must be two bytes wide");
      end
      if (MEM_BYTES < 1 || longint'(MEM_BYTES) > (longint'(1) << ADDR_W)) begin : g_bad_mem
         $error("stk_xfer_unit: MEM_BYTES out of range");
      end
      if (VEC_W + VEC_LSB > ADDR_W) begin : g_bad_vec
         $error("stk_xfer_unit: restart vector does not fit the address");
      end
   endgenerate

   state_e            st_q;
   op_e               op_q;
   logic [ADDR_W-1:0] sp_q, pc_q, pc_nx_q, wbuf_q, rbuf_q, hl_q, res_q;
   logic [BYTE_W-1:0] acc_q;
   logic [FLG_W-1:0]  flg_q;

   logic              take;
   logic [ADDR_W-1:0] st_word;
   logic [BYTE_W-1:0] pop_acc;
   logic [FLG_W-1:0]  pop_flg;
   logic [ADDR_W-1:0] core_addr;
   logic              core_we;
   logic [BYTE_W-1:0] core_wdata, core_rdata;
   logic [ADDR_W-1:0] popped;
   logic [ADDR_W-1:0] pc_p1, pc_p3, sp_p1, sp_m1, vec_addr;
   op_e               op_in;

   assign op_in    = op_e'(cmd_op);
   assign pc_p1    = pc_q + ADDR_W'(LEN_ONE);
   assign pc_p3    = pc_q + ADDR_W'(LEN_LONG);
   assign sp_p1    = sp_q + ADDR_W'(1);
   assign sp_m1    = sp_q - ADDR_W'(1);
   assign vec_addr = ADDR_W'({cmd_vec, {VEC_LSB{1'b0}}});
   assign popped   = {core_rdata, rbuf_q[BYTE_W-1:0]};

   stk_cond_eval #(.SEL_W(COND_W)) u_cond (
      .cond_sel (cmd_cond),
      .flags    (flags_in),
      .take     (take)
   );

   stk_status_codec #(.BYTE_W(BYTE_W)) u_codec (
      .acc_in      (acc_in),
      .flags_in    (flags_in),
      .packed_word (st_word),
      .unpack_word (popped),
      .acc_out     (pop_acc),
      .flags_out   (pop_flg)
   );

   stk_mem_guard #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .MEM_BYTES(MEM_BYTES)) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .core_addr  (core_addr),
      .core_we    (core_we),
      .core_wdata (core_wdata),
      .core_rdata (core_rdata),
      .mem_addr   (mem_addr),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata)
   );

   // memory cycle for each state
   always_comb begin
      core_addr  = sp_q;
      core_we    = 1'b0;
      core_wdata = '0;
      case (st_q)
         ST_WR_HI: begin
            core_addr  = sp_m1;
            core_we    = 1'b1;
            core_wdata = wbuf_q[ADDR_W-1:BYTE_W];
         end
         ST_WR_LO: begin
            core_addr  = sp_m1;
            core_we    = 1'b1;
            core_wdata = wbuf_q[BYTE_W-1:0];
         end
         ST_XR_HI: core_addr = sp_p1;
         ST_XW_LO: begin
            core_we    = 1'b1;
            core_wdata = hl_q[BYTE_W-1:0];
         end
         ST_XW_HI: begin
            core_addr  = sp_p1;
            core_we    = 1'b1;
            core_wdata = hl_q[ADDR_W-1:BYTE_W];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_q    <= OP_PUSH;
         sp_q    <= '0;
         pc_q    <= '0;
         pc_nx_q <= '0;
         wbuf_q  <= '0;
         rbuf_q  <= '0;
         hl_q    <= '0;
         res_q   <= '0;
         acc_q   <= '0;
         flg_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (cmd_valid) begin
               op_q <= op_in;
               hl_q <= hl_in;
               st_q <= ST_FIN;
               case (op_in)
                  OP_PUSH: begin
                     wbuf_q <= cmd_word; pc_nx_q <= pc_p1; st_q <= ST_WR_HI;
                  end
                  OP_PUSH_ST: begin
                     wbuf_q <= st_word; pc_nx_q <= pc_p1; st_q <= ST_WR_HI;
                  end
                  OP_POP, OP_POP_ST, OP_RET: begin
                     pc_nx_q <= pc_p1; st_q <= ST_RD_LO;
                  end
                  OP_RET_CC: begin
                     if (take) begin pc_nx_q <= pc_p1; st_q <= ST_RD_LO; end
                     else pc_q <= pc_p1;
                  end
                  OP_CALL: begin
                     wbuf_q <= pc_p3; pc_nx_q <= cmd_word; st_q <= ST_WR_HI;
                  end
                  OP_CALL_CC: begin
                     if (take) begin
                        wbuf_q <= pc_p3; pc_nx_q <= cmd_word; st_q <= ST_WR_HI;
                     end else pc_q <= pc_p3;
                  end
                  OP_RESTART: begin
                     wbuf_q <= pc_p1; pc_nx_q <= vec_addr; st_q <= ST_WR_HI;
                  end
                  OP_XCHG_TOP: begin
                     pc_nx_q <= pc_p1; st_q <= ST_XR_LO;
                  end
                  OP_JMP:     pc_q <= cmd_word;
                  OP_JMP_CC:  pc_q <= take ? cmd_word : pc_p3;
                  OP_LOAD_SP: sp_q <= cmd_word;
                  default: ;
               endcase
            end
            ST_WR_HI: begin
               sp_q <= sp_m1; st_q <= ST_WR_LO;
            end
            ST_WR_LO: begin
               sp_q <= sp_m1; pc_q <= pc_nx_q; st_q <= ST_FIN;
            end
            ST_RD_LO: begin
               sp_q <= sp_p1; st_q <= ST_RD_HI;
            end
            ST_RD_HI: begin
               sp_q <= sp_p1; rbuf_q[BYTE_W-1:0] <= core_rdata; st_q <= ST_RD_END;
            end
            ST_RD_END: begin
               case (op_q)
                  OP_POP:    begin res_q <= popped; pc_q <= pc_nx_q; end
                  OP_POP_ST: begin acc_q <= pop_acc; flg_q <= pop_flg; pc_q <= pc_nx_q; end
                  default:   pc_q <= popped;
               endcase
               st_q <= ST_FIN;
            end
            ST_XR_LO: st_q <= ST_XR_HI;
            ST_XR_HI: begin
               rbuf_q[BYTE_W-1:0] <= core_rdata; st_q <= ST_XW_LO;
            end
            ST_XW_LO: begin
               rbuf_q[ADDR_W-1:BYTE_W] <= core_rdata; st_q <= ST_XW_HI;
            end
            ST_XW_HI: begin
               res_q <= rbuf_q; pc_q <= pc_nx_q; st_q <= ST_FIN;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready  = (st_q == ST_IDLE);
   assign done       = (st_q == ST_FIN);
   assign pc_out     = pc_q;
   assign sp_out     = sp_q;
   assign result_out = res_q;
   assign acc_out    = acc_q;
   assign flags_out  = flg_q;

endmodule

// File: rtl/stk_xfer_chk.sv
module stk_xfer_chk #(
   parameter int ADDR_W    = 16,
   parameter int MEM_BYTES = 65536
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              done,
   input logic [ADDR_W-1:0] sp_out,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we
);

   localparam logic [ADDR_W:0] LIMIT = MEM_BYTES[ADDR_W:0];

   // R12
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   // R12
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_ready);

   // R10
   write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ({1'b0, mem_addr} < LIMIT));

   // R1 R2 R11
   sp_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sp_out != $past(sp_out)) && !$past(cmd_valid && cmd_ready)) |->
      ((sp_out == ADDR_W'($past(sp_out) + ADDR_W'(1))) ||
       (sp_out == ADDR_W'($past(sp_out) - ADDR_W'(1)))));

endmodule

bind stk_xfer_unit stk_xfer_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .done      (done),
   .sp_out    (sp_out),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we)
);

// File: tb/tb_stk_xfer_unit.sv
`timescale 1ns/1ps
module tb_stk_xfer_unit;

   localparam int LIM = 49152;
   localparam int M16 = 16'hFFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [3:0]  cmd_op = '0;
   logic [2:0]  cmd_cond = '0;
   logic [2:0]  cmd_vec = '0;
   logic [15:0] cmd_word = '0;
   logic [7:0]  acc_in = '0;
   logic [4:0]  flags_in = '0;
   logic [15:0] hl_in = '0;
   logic        done;
   logic [15:0] pc_out, sp_out, result_out, mem_addr;
   logic [7:0]  acc_out, mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic [4:0]  flags_out;
   logic        mem_we;

   always #2 clk = ~clk;

   stk_xfer_unit #(.MEM_BYTES(LIM)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_cond(cmd_cond), .cmd_vec(cmd_vec), .cmd_word(cmd_word),
      .acc_in(acc_in), .flags_in(flags_in), .hl_in(hl_in), .done(done),
      .pc_out(pc_out), .sp_out(sp_out), .result_out(result_out), .acc_out(acc_out),
      .flags_out(flags_out), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // physical memory seen at the ports, no size limit of its own
   logic [7:0] phys [int];
   always @(posedge clk) begin
      logic [7:0] rd_v;
      rd_v = phys.exists(int'(mem_addr)) ? phys[int'(mem_addr)] : 8'h00;
      if (mem_we) phys[int'(mem_addr)] = mem_wdata;
      mem_rdata <= rd_v;
   end

   // behavioural reference
   int ref_pc = 0, ref_sp = 0, ref_res = 0, ref_acc = 0, ref_flg = 0;
   logic [7:0] rmem [int];
   typedef struct { bit we; int addr; int data; bit any; } bus_t;
   bus_t expq[$];
   int n_cmp = 0, n_bad = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int m_rd(int a);
      if (a >= LIM) return 255;
      if (rmem.exists(a)) return int'(rmem[a]);
      return 0;
   endfunction

   function automatic void m_bus(bit we, int a, int d, bit any);
      bus_t b;
      b.we = we; b.addr = a; b.data = d & 255; b.any = any;
      expq.push_back(b);
   endfunction

   function automatic void m_wr(int a, int d);
      m_bus(a < LIM, a, d, 1'b0);
      if (a < LIM) rmem[a] = 8'(d);
   endfunction

   function automatic void m_push(int w);
      ref_sp = (ref_sp - 1) & M16;  m_wr(ref_sp, (w >> 8) & 255);
      ref_sp = (ref_sp - 1) & M16;  m_wr(ref_sp, w & 255);
   endfunction

   function automatic int m_pop();
      int lo, hi;
      lo = m_rd(ref_sp); m_bus(1'b0, ref_sp, 0, 1'b0); ref_sp = (ref_sp + 1) & M16;
      hi = m_rd(ref_sp); m_bus(1'b0, ref_sp, 0, 1'b0); ref_sp = (ref_sp + 1) & M16;
      m_bus(1'b0, 0, 0, 1'b1);
      return (hi << 8) | lo;
   endfunction

   function automatic int pk(int f);
      return (((f >> 4) & 1) << 7) | (((f >> 3) & 1) << 6) | (((f >> 2) & 1) << 4)
           | (((f >> 1) & 1) << 2) | 2 | (f & 1);
   endfunction

   function automatic int upk(int b);
      return (((b >> 7) & 1) << 4) | (((b >> 6) & 1) << 3) | (((b >> 4) & 1) << 2)
           | (((b >> 2) & 1) << 1) | (b & 1);
   endfunction

   function automatic bit cond_ok(int cc, int f);
      int z, c, p, s;
      z = (f >> 3) & 1; c = f & 1; p = (f >> 1) & 1; s = (f >> 4) & 1;
      case (cc)
         0: return z == 0;  1: return z == 1;
         2: return c == 0;  3: return c == 1;
         4: return p == 0;  5: return p == 1;
         6: return s == 0;  default: return s == 1;
      endcase
   endfunction

   task automatic run(input int op, input int cc, input int vec, input int word,
                      input int acc, input int flg, input int hl, input string req);
      int lo, hi;
      expq.delete();
      case (op)
         0: begin m_push(word); ref_pc = (ref_pc + 1) & M16; end
         1: begin ref_res = m_pop(); ref_pc = (ref_pc + 1) & M16; end
         2: begin m_push(((acc & 255) << 8) | pk(flg)); ref_pc = (ref_pc + 1) & M16; end
         3: begin
            lo = m_pop(); ref_acc = (lo >> 8) & 255; ref_flg = upk(lo & 255);
            ref_pc = (ref_pc + 1) & M16;
         end
         4: begin m_push((ref_pc + 3) & M16); ref_pc = word; end
         5: if (cond_ok(cc, flg)) begin m_push((ref_pc + 3) & M16); ref_pc = word; end
            else ref_pc = (ref_pc + 3) & M16;
         6: ref_pc = m_pop();
         7: if (cond_ok(cc, flg)) ref_pc = m_pop();
            else ref_pc = (ref_pc + 1) & M16;
         8: begin m_push((ref_pc + 1) & M16); ref_pc = vec * 8; end
         9: begin
            lo = m_rd(ref_sp);               m_bus(1'b0, ref_sp, 0, 1'b0);
            hi = m_rd((ref_sp + 1) & M16);   m_bus(1'b0, (ref_sp + 1) & M16, 0, 1'b0);
            m_wr(ref_sp, hl & 255);
            m_wr((ref_sp + 1) & M16, (hl >> 8) & 255);
            ref_res = (hi << 8) | lo;
            ref_pc = (ref_pc + 1) & M16;
         end
         10: ref_pc = word;
         11: ref_pc = cond_ok(cc, flg) ? word : ((ref_pc + 3) & M16);
         12: ref_sp = word;
         default: ;
      endcase

      @(negedge clk);
      chk(req, "ready in idle", {31'd0, cmd_ready}, 1);
      chk(req, "done in idle", {31'd0, done}, 0);
      cmd_valid = 1'b1; cmd_op = op[3:0]; cmd_cond = cc[2:0]; cmd_vec = vec[2:0];
      cmd_word = word[15:0]; acc_in = acc[7:0]; flags_in = flg[4:0]; hl_in = hl[15:0];
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < expq.size(); i++) begin
         chk(req, "ready low while busy", {31'd0, cmd_ready}, 0);  // R12
         chk(req, "done low while busy", {31'd0, done}, 0);
         chk(req, "write enable", {31'd0, mem_we}, {31'd0, expq[i].we});
         if (!expq[i].any) chk(req, "bus address", {16'd0, mem_addr}, expq[i].addr);
         if (expq[i].we)   chk(req, "write byte", {24'd0, mem_wdata}, expq[i].data);
         @(negedge clk);
      end
      chk(req, "done pulse", {31'd0, done}, 1);
      chk(req, "ready during done", {31'd0, cmd_ready}, 0);          // R12
      chk(req, "pc", {16'd0, pc_out}, ref_pc);
      chk(req, "sp", {16'd0, sp_out}, ref_sp);
      chk(req, "result", {16'd0, result_out}, ref_res);
      chk(req, "acc", {24'd0, acc_out}, ref_acc);
      chk(req, "flags", {27'd0, flags_out}, ref_flg);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R13 reset state
      chk("R13", "reset pc", {16'd0, pc_out}, 0);
      chk("R13", "reset sp", {16'd0, sp_out}, 0);
      chk("R13", "reset ready in reset", {31'd0, cmd_ready}, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13", "reset result", {16'd0, result_out}, 0);
      chk("R13", "reset done", {31'd0, done}, 0);

      run(12, 0, 0, 16'h2000, 0, 0, 0, "R13");
      run(10, 0, 0, 16'h0100, 0, 0, 0, "R13");
      run(15, 0, 0, 16'h9999, 0, 5'h1F, 0, "R13");
      run(13, 0, 0, 16'h1111, 0, 0, 0, "R13");

      run(0, 0, 0, 16'hBEEF, 0, 0, 0, "R1");
      run(0, 0, 0, 16'h0102, 0, 0, 0, "R1");
      run(1, 0, 0, 0, 0, 0, 0, "R2");
      run(1, 0, 0, 0, 0, 0, 0, "R2");

      run(2, 0, 0, 0, 8'h5A, 5'h00, 0, "R3");
      run(2, 0, 0, 0, 8'hA5, 5'h1F, 0, "R3");
      run(3, 0, 0, 0, 0, 0, 0, "R4");
      run(3, 0, 0, 0, 0, 0, 0, "R4");
      run(0, 0, 0, 16'h3C2A, 0, 0, 0, "R4");
      run(3, 0, 0, 0, 0, 0, 0, "R4");
      run(0, 0, 0, 16'h81FF, 0, 0, 0, "R4");
      run(3, 0, 0, 0, 0, 0, 0, "R4");

      run(4, 0, 0, 16'h1234, 0, 0, 0, "R6");
      run(6, 0, 0, 0, 0, 0, 0, "R7");

      for (int cc = 0; cc < 8; cc++) begin
         run(5, cc, 0, 16'h4000 + cc * 16, 0, 5'h00, 0, "R5 R6");
         run(5, cc, 0, 16'h4800 + cc * 16, 0, 5'h1F, 0, "R5 R6");
      end
      for (int cc = 0; cc < 8; cc++) begin
         run(7, cc, 0, 0, 0, 5'h00, 0, "R5 R7");
         run(7, cc, 0, 0, 0, 5'h1F, 0, "R5 R7");
      end
      run(11, 2, 0, 16'h5555, 0, 5'h01, 0, "R5");
      run(11, 3, 0, 16'h6666, 0, 5'h01, 0, "R5");

      run(8, 0, 5, 0, 0, 0, 0, "R8");
      run(8, 0, 7, 0, 0, 0, 0, "R8");
      run(8, 0, 0, 0, 0, 0, 0, "R8");

      run(0, 0, 0, 16'h1122, 0, 0, 0, "R9");
      run(9, 0, 0, 0, 0, 0, 16'hAABB, "R9");
      run(1, 0, 0, 0, 0, 0, 0, "R9");

      run(12, 0, 0, 16'hC002, 0, 0, 0, "R10");
      run(0, 0, 0, 16'h7788, 0, 0, 0, "R10");
      run(1, 0, 0, 0, 0, 0, 0, "R10");
      chk("R10", "no write past limit", {31'd0, phys.exists(49152)}, 0);
      chk("R10", "no write past limit", {31'd0, phys.exists(49153)}, 0);

      run(12, 0, 0, 16'h0001, 0, 0, 0, "R11");
      run(0, 0, 0, 16'h1357, 0, 0, 0, "R11");
      run(1, 0, 0, 0, 0, 0, 0, "R11");
      run(12, 0, 0, 16'h3000, 0, 0, 0, "R11");
      run(10, 0, 0, 16'hFFFE, 0, 0, 0, "R11");
      run(4, 0, 0, 16'h0040, 0, 0, 0, "R11");
      run(6, 0, 0, 0, 0, 0, 0, "R11");

      @(negedge clk);
      chk("R12", "ready back after done", {31'd0, cmd_ready}, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule